// File: doc/BRIEF.md
# Double-Buffered Serial-to-Parallel Register

This block takes a bit stream on one wire and turns it into a parallel word. Each clock with the shift enable high moves one new bit into an internal shift stage. The word that the outside world sees comes from a separate holding register, not from the shift stage. That holding register changes only when a load strobe arrives, and the load copies the whole shift stage in one clock. A new word can therefore be assembled bit by bit while the parallel outputs keep showing the previous word without any ripple.

The last bit of the shift stage leaves the block as a serial output, so several of these blocks can be chained into one long register. A synchronous clear empties the shift stage and leaves the displayed word alone. An output enable gates the parallel outputs to zero and does not disturb any stored bit. Every storage element is edge triggered on the same clock. The asynchronous active-low reset is released through an internal two-stage synchroniser.

Top module: `sipo_latched_out`

## Requirements
- R1: While reset is asserted, and for the two clocks after it is released, par_out and ser_out are 0.
- R2: With shift_en high and clr_stage low, each clock moves the shift stage one place toward the high end and puts ser_in into bit 0. A bit presented at ser_in therefore sits in stage bit k after k+1 shifts. Shifting in the bits of a word from its most significant bit down to bit 0 leaves the stage equal to that word.
- R3: While load_stb is low, par_out stays constant whatever happens on ser_in, shift_en and clr_stage.
- R4: A clock with load_stb high copies all WIDTH bits of the shift stage into the holding register. The new word appears on par_out after that edge.
- R5: When load_stb and shift_en are high in the same clock, the holding register receives the stage contents from before that clock's shift.
- R6: clr_stage zeroes the shift stage on the next clock and takes priority over shift_en. The holding register and par_out are unchanged. A load in the same clock captures the stage contents from before the clear.
- R7: When out_en is low, par_out is all zeros. Both registers keep their contents, and raising out_en shows the held word again.
- R8: ser_out always equals the top stage bit (bit WIDTH-1). A bit entered at ser_in appears on ser_out after WIDTH shifts, which allows cascading.
- R9: With shift_en and clr_stage low, the shift stage holds its contents whatever ser_in does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all storage |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_in | input | 1 | Serial data bit taken on a shift |
| shift_en | input | 1 | Shift the stage by one place this clock |
| clr_stage | input | 1 | Synchronous clear of the shift stage only |
| load_stb | input | 1 | Copy the shift stage into the holding register |
| out_en | input | 1 | High shows the held word, low forces par_out to zero |
| par_out | output | WIDTH | Gated contents of the holding register |
| ser_out | output | 1 | Top shift-stage bit, for chaining |

## Verification
The bench runs a four-bit instance and shifts in every one of the sixteen possible words, most significant bit first. Between loads it watches par_out on every shift and checks that it still shows the previous word, then checks that the load makes exactly the new word appear; this tells a correct bit order and a clean double buffer apart from reversed or rippling outputs. Targeted sequences also combine operations in the same clock: shift with load (to tell old contents from new), clear with shift, and clear with load. Further sequences drive ser_in while shifting is idle and toggle the output enable around a load, which shows that the stored state survives. One word is then pushed all the way out of ser_out to check the cascade delay.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

  // Operation the shift stage performs in a given cycle.
  typedef enum logic [1:0] {
    STG_HOLD  = 2'd0,
    STG_SHIFT = 2'd1,
    STG_CLEAR = 2'd2
  } stage_op_e;

  // Clear outranks shift; nothing requested means hold.
  function automatic stage_op_e decode_stage_op(input logic shift_req,
                                                input logic clear_req);
    stage_op_e op;
    if (clear_req)      op = STG_CLEAR;
    else if (shift_req) op = STG_SHIFT;
    else                op = STG_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/sipo_rst_sync.sv
module sipo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_en,
  input  logic             clr_stage,
  output logic [WIDTH-1:0] stage_q
);

  stage_op_e        op;
  logic [WIDTH-1:0] stage_d;
  logic             stage_we;

  always_comb begin
    op       = decode_stage_op(shift_en, clr_stage);
    stage_we = 1'b0;
    stage_d  = stage_q;
    unique case (op)
      STG_SHIFT: begin
        stage_we = 1'b1;
        stage_d  = {stage_q[WIDTH-2:0], ser_in};
      end
      STG_CLEAR: begin
        stage_we = 1'b1;
        stage_d  = '0;
      end
      default: begin
        stage_we = 1'b0;
        stage_d  = stage_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_we) stage_q <= stage_d;
  end

endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_stb,
  input  logic [WIDTH-1:0] stage_q,
  output logic [WIDTH-1:0] hold_q
);

  logic [WIDTH-1:0] hold_d;

  always_comb begin
    hold_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (load_stb) hold_q <= hold_d;
  end

endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             out_en,
  input  logic [WIDTH-1:0] hold_q,
  output logic [WIDTH-1:0] par_out
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign par_out[b] = hold_q[b] & out_en;
  end

endmodule

// File: rtl/sipo_latched_out.sv
module sipo_latched_out #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_en,
  input  logic             clr_stage,
  input  logic             load_stb,
  input  logic             out_en,
  output logic [WIDTH-1:0] par_out,
  output logic             ser_out
);

  logic             rst_sync_n;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] hold_q;

  sipo_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sipo_shift_stage #(.WIDTH(WIDTH)) u_stage (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ser_in    (ser_in),
    .shift_en  (shift_en),
    .clr_stage (clr_stage),
    .stage_q   (stage_q)
  );

  sipo_hold_reg #(.WIDTH(WIDTH)) u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_stb (load_stb),
    .stage_q  (stage_q),
    .hold_q   (hold_q)
  );

  sipo_out_gate #(.WIDTH(WIDTH)) u_gate (
    .out_en  (out_en),
    .hold_q  (hold_q),
    .par_out (par_out)
  );

  assign ser_out = stage_q[WIDTH-1];

endmodule

// File: rtl/sipo_latched_out_chk.sv
module sipo_latched_out_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic             clr_stage,
  input logic             load_stb,
  input logic             out_en,
  input logic [WIDTH-1:0] par_out,
  input logic             ser_out,
  input logic [WIDTH-1:0] stage_q
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (par_out == '0 || rst_n)); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && $past(out_en) && !$past(load_stb)) |-> $stable(par_out)); // R3

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_stb) && out_en) |-> par_out == $past(stage_q)); // R4

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shift_en && !clr_stage) |-> stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0])); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_stage) |-> stage_q == '0); // R6

  AST_OE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> par_out == '0); // R7

  AST_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shift_en && !clr_stage) |-> ser_out == $past(stage_q[WIDTH-2])); // R8

  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!shift_en && !clr_stage) |-> $stable(stage_q)); // R9

endmodule

bind sipo_latched_out sipo_latched_out_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shift_en  (shift_en),
  .clr_stage (clr_stage),
  .load_stb  (load_stb),
  .out_en    (out_en),
  .par_out   (par_out),
  .ser_out   (ser_out),
  .stage_q   (stage_q)
);

// File: tb/test_sipo_latched_out.sv
`timescale 1ns/1ps
module test_sipo_latched_out;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ser_in, shift_en, clr_stage, load_stb, out_en;
  logic [W-1:0] par_out;
  logic         ser_out;

  int errors = 0;
  int checks = 0;

  logic [W-1:0] m_stage;
  logic [W-1:0] m_hold;

  always #5 clk = ~clk;

  sipo_latched_out #(.WIDTH(W)) i_sipo_latched_out (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_en(shift_en),
    .clr_stage(clr_stage), .load_stb(load_stb), .out_en(out_en),
    .par_out(par_out), .ser_out(ser_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive inputs, take the edge, update the model, compare outputs.
  task automatic cyc(input logic sh, input logic si, input logic ld,
                     input logic cl, input logic oe, input string req);
    shift_en = sh; ser_in = si; load_stb = ld; clr_stage = cl; out_en = oe;
    @(posedge clk); #1;
    if (ld) m_hold = m_stage;
    if (cl)      m_stage = '0;
    else if (sh) m_stage = {m_stage[W-2:0], si};
    check(req, {28'd0, par_out}, {28'd0, (oe ? m_hold : 4'd0)});
    check("R8", {31'd0, ser_out}, {31'd0, m_stage[W-1]});
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_in = 0; shift_en = 0; clr_stage = 0; load_stb = 0; out_en = 1;
    m_stage = '0; m_hold = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {28'd0, par_out}, 32'd0);
    check("R1", {31'd0, ser_out}, 32'd0);
    ser_in = 1; shift_en = 1; load_stb = 1;
    rst_n = 1'b1;
    repeat (2) begin
      @(posedge clk); #1;
      check("R1", {28'd0, par_out}, 32'd0);
    end
    shift_en = 0; load_stb = 0; ser_in = 0;
    @(posedge clk); #1;

    // R2 R3 R4: every word, MSB first, par_out steady until load
    for (int v = 0; v < 16; v++) begin
      for (int b = W - 1; b >= 0; b--) cyc(1'b1, v[b], 1'b0, 1'b0, 1'b1, "R3");
      check("R2", {28'd0, m_stage}, v);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
      check("R4", {28'd0, par_out}, v);
    end

    // R5: shift and load together take the old stage
    for (int b = W - 1; b >= 0; b--) cyc(1'b1, 4'hA >> b, 1'b0, 1'b0, 1'b1, "R3");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
    check("R5", {28'd0, par_out}, 32'hA);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
    check("R5", {28'd0, par_out}, 32'h5);

    // R9: idle stage ignores ser_in
    for (int k = 0; k < 4; k++) cyc(1'b0, k[0], 1'b0, 1'b0, 1'b1, "R9");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
    check("R9", {28'd0, par_out}, 32'h5);

    // R6: clear keeps par_out, wins over shift, load with clear gets old stage
    for (int b = W - 1; b >= 0; b--) cyc(1'b1, 4'hC >> b, 1'b0, 1'b0, 1'b1, "R3");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
    check("R6", {28'd0, par_out}, 32'hC);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R6");
    check("R6", {28'd0, par_out}, 32'h0);
    for (int b = W - 1; b >= 0; b--) cyc(1'b1, 4'h9 >> b, 1'b0, 1'b0, 1'b1, "R3");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
    check("R6", {28'd0, par_out}, 32'h9);
    check("R6", {31'd0, ser_out}, 32'd0);

    // R7: output enable blanks without losing contents
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    check("R7", {28'd0, par_out}, 32'h0);
    for (int b = W - 1; b >= 0; b--) cyc(1'b1, 4'h6 >> b, 1'b0, 1'b0, 1'b0, "R7");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    check("R7", {28'd0, par_out}, 32'h9);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
    check("R7", {28'd0, par_out}, 32'h0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    check("R7", {28'd0, par_out}, 32'h6);

    // R8: stage word 6 (0110) leaves on ser_out as 0,1,1,0
    for (int k = 0; k < W; k++) begin
      check("R8", {31'd0, ser_out}, (32'h6 >> (W - 1 - k)) & 32'h1);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    end
    check("R8", {31'd0, ser_out}, 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule